// File: doc/BRIEF.md
# Multidrop Serial Receiver with Slave Address Filter

This block receives asynchronous serial frames on a single line, oversampled by sixteen through an enable tick that comes from an external baud generator. A frame opens with a low start bit. Eight data bits follow, least significant first. In nine-bit mode a ninth bit comes next, and a high stop bit ends the frame. The decided byte appears on `rxData`, the ninth bit on `rxBit9`, and `rxFlag` rises to announce it. A low stop bit raises a sticky framing-error flag, which only a software clear pulse removes. The status output `statusTop` shows either the mode bit or the error flag, as chosen by `errViewSel`.

On a multidrop bus the receiver can run in multiprocessor mode. In that mode, in nine-bit framing, a frame whose ninth bit is 0 is a data frame and is dropped. A frame whose ninth bit is 1 is an address frame. It is kept only when it passes one of two tests:
- the directed test: the address agrees with `slaveAddr` on every bit where `addrMask` is 1;
- the broadcast test: the address is 1 on every bit where `slaveAddr | addrMask` is 1.

Once an address frame is kept, software clears `mpEnable` to take the data frames that follow. Each bit is decided by a majority of three samples around mid-bit.

Top module: `uart_mp_rx`

## Requirements
- R1: A frame is a low start bit, then `DATA_W` data bits least significant first, then one ninth bit only when `modeSel` is 1, then a stop bit. An accepted frame loads `rxData` and sets `rxFlag` one clock after the stop bit is decided.
- R2: Each bit is decided by a majority of the line samples at oversample positions 7, 8 and 9, counting the sample that detects the start as 0. A single wrong sample does not change the bit. A start bit that votes high is dropped, and the receiver returns to idle with no flag.
- R3: A stop bit that votes 0 sets `frameErr`. The frame is still delivered under the rules of R8 and R9. `frameErr` stays 1 until a one-clock pulse on `frameErrClr`.
- R4: `statusTop` equals `frameErr` when `errViewSel` is 1 and `modeSel` when it is 0.
- R5: The directed test passes when `rxAddr` equals `slaveAddr` on every bit where `addrMask` is 1. For example, with address 8'hC0 and mask 8'hFD, 8'hC2 passes and 8'hC1 fails.
- R6: The broadcast test passes when `rxAddr` is 1 on every bit where `slaveAddr | addrMask` is 1, so 8'hFF always passes.
- R7: With `slaveAddr` and `addrMask` both zero, every address frame is accepted.
- R8: The filter acts only when `modeSel` and `mpEnable` are both 1. In that case a frame with ninth bit 0 is dropped, and a frame with ninth bit 1 is accepted only if it passes R5 or R6. In every other case all frames are accepted.
- R9: While `rxFlag` is 1, a new frame changes neither `rxData` nor `rxBit9`, and the frame is lost. `rxFlagClr` clears `rxFlag`.
- R10: While `rxEnable` is 0 the receiver stays idle and line activity changes no output.
- R11: In eight-bit mode (`modeSel` = 0), `rxBit9` takes the decided stop bit of the accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| rxLine | input | 1 | serial input line, idle high |
| sampleTick | input | 1 | one-clock enable at 16 times the bit rate |
| modeSel | input | 1 | 1: nine-bit frames, 0: eight-bit frames |
| rxEnable | input | 1 | receiver enable |
| mpEnable | input | 1 | multiprocessor address filtering enable |
| slaveAddr | input | DATA_W | slave address |
| addrMask | input | DATA_W | address mask, 1 marks a cared bit |
| errViewSel | input | 1 | picks what `statusTop` shows |
| rxFlagClr | input | 1 | clear pulse for `rxFlag` |
| frameErrClr | input | 1 | clear pulse for `frameErr` |
| rxData | output | DATA_W | received byte |
| rxBit9 | output | 1 | ninth bit, or stop bit in eight-bit mode |
| rxFlag | output | 1 | receive flag |
| frameErr | output | 1 | sticky framing error |
| statusTop | output | 1 | mode bit or framing error |

## Verification
The address filter is tried with a single mask that keeps 8'hC2 and rejects 8'hC1, with the all-ones broadcast address, and with an all-zero address and mask. Together these separate the directed test, the broadcast test and the disabled filter. Data frames with ninth bit 0 are sent with the filter on and off, which shows the drop depends on the mode combination. Random frames, with random modes, masks, stop bits and skipped clears, mix held flags with framing errors. Directed cases cover a start glitch, a one-sample data glitch and a disabled receiver, to check that stray line activity changes no output.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_BIT9,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftEn;   // a data bit was decided
    logic bit9En;    // the ninth bit was decided
    logic finishEn;  // the stop bit was decided
    logic bitVal;    // majority value of the decided bit
  } rxStrobe_t;

endpackage

// File: rtl/uart_mp_rx_ctrl.sv
module uart_mp_rx_ctrl
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineSync,
  input  logic      rxEnable,
  input  logic      nineBit,
  output rxStrobe_t strobe
);

  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  CNT_EARLY = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0]  CNT_MID   = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0]  CNT_VOTE  = CNT_W'(OVERSAMPLE / 2 + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIDX_W-1:0] BIT_LAST  = BIDX_W'(DATA_W - 1);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIDX_W-1:0] bitIdx;
  logic              sEarly, sMid;
  logic              vote, atVote, atEnd;

  assign vote   = (sEarly & sMid) | (sEarly & lineSync) | (sMid & lineSync);
  assign atVote = sampleTick && (tickCnt == CNT_VOTE);
  assign atEnd  = sampleTick && (tickCnt == CNT_LAST);

  always_comb begin
    strobe.shiftEn  = (state == ST_DATA) && atVote;
    strobe.bit9En   = (state == ST_BIT9) && atVote;
    strobe.finishEn = (state == ST_STOP) && atVote;
    strobe.bitVal   = vote;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      sEarly  <= 1'b1;
      sMid    <= 1'b1;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (state == ST_IDLE) begin
      if (sampleTick && !lineSync) begin
        state   <= ST_START;
        tickCnt <= CNT_W'(1);
        bitIdx  <= '0;
      end
    end else if (sampleTick) begin
      if (tickCnt == CNT_EARLY) sEarly <= lineSync;
      if (tickCnt == CNT_MID)   sMid   <= lineSync;
      tickCnt <= (tickCnt == CNT_LAST) ? '0 : tickCnt + CNT_W'(1);
      unique case (state)
        ST_START: begin
          if (atVote && vote) begin
            state <= ST_IDLE;
          end else if (atEnd) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (atEnd) begin
            if (bitIdx == BIT_LAST) begin
              state <= nineBit ? ST_BIT9 : ST_STOP;
            end else begin
              bitIdx <= bitIdx + BIDX_W'(1);
            end
          end
        end
        ST_BIT9: if (atEnd) state <= ST_STOP;
        ST_STOP: if (atVote) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftEn, strobe.bit9En, strobe.finishEn}));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE && rxEnable && $past(rxEnable))
      |=> (state == ST_IDLE || !$past(lineSync)));

endmodule

// File: rtl/uart_mp_rx_addr_filter.sv
module uart_mp_rx_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rxAddr,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  output logic              addrHit
);

  logic [DATA_W-1:0] directMiss, bcastMiss;
  logic directHit, bcastHit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign directMiss[i] = addrMask[i] & (rxAddr[i] ^ slaveAddr[i]);
    assign bcastMiss[i]  = (slaveAddr[i] | addrMask[i]) & ~rxAddr[i];
  end

  assign directHit = ~|directMiss;
  assign bcastHit  = ~|bcastMiss;
  assign addrHit   = directHit | bcastHit;

  always_comb begin
    if (addrMask == '0) begin
      p_mask_zero_hit_r7: assert (addrHit);
    end
    if (&rxAddr) begin
      p_all_ones_bcast_r6: assert (bcastHit);
    end
  end

endmodule

// File: rtl/uart_mp_rx_datapath.sv
module uart_mp_rx_datapath
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic              nineBit,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              rxFlagClr,
  input  logic              frameErrClr,
  output logic              lineSync,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              frameErr
);

  logic [1:0]        syncReg;
  logic [DATA_W-1:0] shiftReg;
  logic              bit9Reg;
  logic              addrHit, filterOn, acceptFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[0], rxLine};
  end
  assign lineSync = syncReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bit9Reg  <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {strobe.bitVal, shiftReg[DATA_W-1:1]};
      if (strobe.bit9En)  bit9Reg  <= strobe.bitVal;
    end
  end

  uart_mp_rx_addr_filter #(.DATA_W(DATA_W)) filter_i (
    .rxAddr    (shiftReg),
    .slaveAddr (slaveAddr),
    .addrMask  (addrMask),
    .addrHit   (addrHit)
  );

  assign filterOn    = nineBit && mpEnable;
  assign acceptFrame = strobe.finishEn && !rxFlag &&
                       (!filterOn || (bit9Reg && addrHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxFlag   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (acceptFrame) begin
        rxData <= shiftReg;
        rxBit9 <= nineBit ? bit9Reg : strobe.bitVal;
        rxFlag <= 1'b1;
      end else if (rxFlagClr) begin
        rxFlag <= 1'b0;
      end
      if (strobe.finishEn && !strobe.bitVal) frameErr <= 1'b1;
      else if (frameErrClr)                  frameErr <= 1'b0;
    end
  end

  p_fe_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !frameErrClr) |=> frameErr);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && $past(rxFlag)) |-> ($stable(rxData) && $stable(rxBit9)));

  p_flag_after_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(strobe.finishEn));

  p_mp_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishEn && filterOn && !bit9Reg) |=> (rxFlag == $past(rxFlag)));

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              modeSel,
  input  logic              rxEnable,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              errViewSel,
  input  logic              rxFlagClr,
  input  logic              frameErrClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              frameErr,
  output logic              statusTop
);

  rxStrobe_t strobe;
  logic      lineSync;

  uart_mp_rx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineSync   (lineSync),
    .rxEnable   (rxEnable),
    .nineBit    (modeSel),
    .strobe     (strobe)
  );

  uart_mp_rx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .strobe      (strobe),
    .nineBit     (modeSel),
    .mpEnable    (mpEnable),
    .slaveAddr   (slaveAddr),
    .addrMask    (addrMask),
    .rxFlagClr   (rxFlagClr),
    .frameErrClr (frameErrClr),
    .lineSync    (lineSync),
    .rxData      (rxData),
    .rxBit9      (rxBit9),
    .rxFlag      (rxFlag),
    .frameErr    (frameErr)
  );

  assign statusTop = errViewSel ? frameErr : modeSel;

endmodule

// File: tb/uart_mp_rx_tb.sv
module uart_mp_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic modeSel = 1'b0, rxEnable = 1'b0, mpEnable = 1'b0;
  logic errViewSel = 1'b0, rxFlagClr = 1'b0, frameErrClr = 1'b0;
  logic [DATA_W-1:0] slaveAddr = '0, addrMask = '0;
  logic [DATA_W-1:0] rxData;
  logic rxBit9, rxFlag, frameErr, statusTop;
  logic [1:0] div;
  logic sampleTick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] expData = '0;
  logic expBit9 = 1'b0, expFlag = 1'b0, expFe = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) div <= '0;
    else       div <= div + 2'd1;
  end
  assign sampleTick = (div == 2'd3);

  uart_mp_rx #(.DATA_W(DATA_W), .OVERSAMPLE(16)) dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .modeSel(modeSel), .rxEnable(rxEnable), .mpEnable(mpEnable),
    .slaveAddr(slaveAddr), .addrMask(addrMask), .errViewSel(errViewSel),
    .rxFlagClr(rxFlagClr), .frameErrClr(frameErrClr),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag),
    .frameErr(frameErr), .statusTop(statusTop)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns after the clock edge that consumed a tick, away from the edge
  task automatic tickWait(input int n);
    for (int k = 0; k < n; k++) begin
      do begin
        @(posedge clk);
        #1;
      end while (div != 2'd0);
    end
  endtask

  function automatic bit addrMatch(input logic [7:0] a, input logic [7:0] sa,
                                   input logic [7:0] m);
    bit dir = 1'b1;
    bit bc  = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (m[i] && (a[i] != sa[i])) dir = 1'b0;
      if ((sa[i] || m[i]) && !a[i]) bc = 1'b0;
    end
    return dir || bc;
  endfunction

  task automatic checkAll(input string req);
    chk({req, " rxFlag"},   int'(rxFlag),   int'(expFlag));
    chk({req, " rxData"},   int'(rxData),   int'(expData));
    chk({req, " rxBit9"},   int'(rxBit9),   int'(expBit9));
    chk({req, " frameErr"}, int'(frameErr), int'(expFe));
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic b9, input logic stopBit,
                           input int glitchBit, input string req);
    logic [10:0] bits;
    int nBits;
    bit accept;
    nBits = modeSel ? 11 : 10;
    bits  = modeSel ? {stopBit, b9, d, 1'b0} : {1'b0, stopBit, d, 1'b0};
    for (int p = 0; p < nBits; p++) begin
      for (int t = 0; t < 16; t++) begin
        rxLine = (p == glitchBit + 1 && t == 8) ? ~bits[p] : bits[p];
        tickWait(1);
      end
    end
    rxLine = 1'b1;
    tickWait(24);
    if (rxEnable) begin
      if (!stopBit) expFe = 1'b1;
      accept = !expFlag && (!(modeSel && mpEnable) ||
                            (b9 && addrMatch(d, slaveAddr, addrMask)));
      if (accept) begin
        expData = d;
        expBit9 = modeSel ? b9 : stopBit;
        expFlag = 1'b1;
      end
    end
    checkAll(req);
  endtask

  task automatic swClear(input bit clrFlag, input bit clrFe);
    @(posedge clk); #1;
    rxFlagClr   = clrFlag;
    frameErrClr = clrFe;
    @(posedge clk); #1;
    rxFlagClr   = 1'b0;
    frameErrClr = 1'b0;
    if (clrFlag) expFlag = 1'b0;
    if (clrFe)   expFe   = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // reset state
    checkAll("R1 reset");
    chk("R4 reset statusTop", int'(statusTop), 0);
    rxEnable = 1'b1;

    // eight-bit frame, stop bit goes to rxBit9
    sendFrame(8'hA5, 1'b0, 1'b1, -1, "R1 R11 8-bit");
    swClear(1, 0);
    // nine-bit, filter off, data frame accepted
    modeSel = 1'b1;
    sendFrame(8'h3C, 1'b0, 1'b1, -1, "R1 R8 9-bit no-mp");
    swClear(1, 0);
    // framing error is sticky and frame still delivered
    sendFrame(8'h81, 1'b1, 1'b0, -1, "R3 bad stop");
    swClear(1, 0);
    sendFrame(8'h42, 1'b0, 1'b1, -1, "R3 sticky");
    errViewSel = 1'b1; #1;
    chk("R4 shows frameErr", int'(statusTop), 1);
    swClear(1, 1);
    chk("R3 cleared", int'(frameErr), 0);
    chk("R4 shows cleared frameErr", int'(statusTop), 0);
    errViewSel = 1'b0; #1;
    chk("R4 shows modeSel", int'(statusTop), 1);

    // directed filter
    mpEnable = 1'b1; slaveAddr = 8'hC0; addrMask = 8'hFD;
    sendFrame(8'hC2, 1'b1, 1'b1, -1, "R5 C2 match");
    chk("R5 C2 flag", int'(rxFlag), 1);
    swClear(1, 0);
    sendFrame(8'hC1, 1'b1, 1'b1, -1, "R5 C1 reject");
    chk("R5 C1 no flag", int'(rxFlag), 0);
    sendFrame(8'h55, 1'b0, 1'b1, -1, "R8 data dropped");
    chk("R8 no flag", int'(rxFlag), 0);
    sendFrame(8'hFF, 1'b1, 1'b1, -1, "R6 broadcast");
    chk("R6 flag", int'(rxFlag), 1);
    swClear(1, 0);
    // filter disabled by zero registers
    slaveAddr = 8'h00; addrMask = 8'h00;
    sendFrame(8'h17, 1'b1, 1'b1, -1, "R7 any address");
    chk("R7 flag", int'(rxFlag), 1);
    // held flag: second frame lost
    mpEnable = 1'b0;
    sendFrame(8'hE4, 1'b0, 1'b1, -1, "R9 held");
    chk("R9 data kept", int'(rxData), 8'h17);
    swClear(1, 0);
    // disabled receiver
    rxEnable = 1'b0;
    sendFrame(8'h99, 1'b0, 1'b0, -1, "R10 disabled");
    chk("R10 no flag", int'(rxFlag), 0);
    rxEnable = 1'b1;
    // start glitch
    rxLine = 1'b0; tickWait(4); rxLine = 1'b1; tickWait(30);
    chk("R2 start glitch no flag", int'(rxFlag), 0);
    sendFrame(8'h6D, 1'b1, 1'b1, 3, "R2 data glitch");
    chk("R2 glitch data", int'(rxData), 8'h6D);
    swClear(1, 1);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      modeSel   = 1'($urandom_range(0, 1));
      mpEnable  = 1'($urandom_range(0, 1));
      slaveAddr = 8'($urandom);
      addrMask  = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      d = ($urandom_range(0, 3) == 0) ? (slaveAddr & addrMask) | ~addrMask & 8'($urandom)
                                      : 8'($urandom);
      sendFrame(d, 1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0), -1,
                "R1 R3 R5 R6 R8 R9 random");
      swClear(($urandom_range(0, 2) != 0), ($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule